// File: doc/BRIEF.md
# Cartridge Bank Switching Mapper

This block sits between a CPU bus with 24-bit byte addresses and a cartridge ROM larger than the CPU can see at once. The lowest 4 MB of CPU space is a cartridge window cut into eight 512 KB windows. Window 0 always shows the first 512 KB page of ROM. Each of windows 1 to 7 shows whatever ROM page its bank register names, so the physical ROM address is the bank number followed by the 19-bit offset inside the window.

The bank registers are written through a small I/O page at 0xA13000–0xA130FF. Register 0 does not hold a bank. It is a control register. Its bit 0 lets save RAM take over the upper half of the cartridge window (0x200000–0x3FFFFF). Its bits 1:0 must read 01 for a write into save RAM to be passed on. The block is purely a decoder and a register file. It drives a physical ROM address and select, and a save-RAM select, offset and write enable. It holds no storage of its own.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, control register 0 holds 0 and window i (1 to 7) maps to ROM page i, so every cartridge address maps to the identical physical ROM address.
- R2: A register write happens only for a selected write whose address bits 23:8 equal 0xA130. The register index is address bits 3:1, and address bits 7:4 are not decoded. A write to any other address leaves every register unchanged.
- R3: A byte write (bus_byte=1) to an odd address loads bus_wdata[7:0] and a byte write to an even address is ignored; a word write (bus_byte=0) loads bus_wdata; in each case the low BANK_W bits are kept.
- R4: Window 0 (addresses 0x000000–0x07FFFF) always maps to ROM page 0, whatever the registers hold.
- R5: In windows 1 to 7, rom_addr equals bank × 0x80000 plus address bits 18:0, where bank is the register numbered by address bits 21:19.
- R6: When register 0 bit 0 is 1, accesses to 0x200000–0x3FFFFF assert save_sel, deassert rom_sel and present address bits 20:0 on save_off. When bit 0 is 0, those addresses go to ROM through their bank registers.
- R7: save_we is 1 only for a write to the save region while register 0 bits 1:0 equal 01. Values 11, 10 and 00 never assert save_we.
- R8: A register write changes translation from the next clock cycle on. The first access after the write already uses the new value.
- R9: Addresses at or above 0x400000 (including the register page) assert neither rom_sel nor save_sel.
- R10: With bus_sel low, no select, no save write and no register write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_byte | input | 1 | Access is a byte access (0 = word) |
| bus_addr | input | 24 | CPU byte address |
| bus_wdata | input | 16 | Write data |
| rom_addr | output | BANK_W+PAGE_BITS (25) | Physical ROM byte address |
| rom_sel | output | 1 | ROM access this cycle |
| save_sel | output | 1 | Save-RAM access this cycle |
| save_we | output | 1 | Qualified save-RAM write |
| save_off | output | WIN_BITS+PAGE_BITS-1 (21) | Byte offset inside the save region |

## Verification
Banking and the save overlay both claim the windows at 0x200000–0x3FFFFF in the same cycle, and the overlay must win. The bench turns the overlay on and then rewrites a bank register of an upper window. It checks that the window still decodes to save RAM. It then clears the overlay and checks that the very next access returns ROM through the bank value that was written while it was hidden. Expected addresses come from an arithmetic model held in the bench. The model is updated by hand for each write, after the window and bank sweep.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  localparam int BUS_W = 24;
  localparam logic [15:0] REG_PAGE = 16'hA130;

  typedef enum logic [1:0] {
    CTL_ROM      = 2'b00,
    CTL_SAVE_RW  = 2'b01,
    CTL_ROM_ALT  = 2'b10,
    CTL_SAVE_RO  = 2'b11
  } ctl_mode_e;

  function automatic logic in_reg_page(input logic [BUS_W-1:0] a);
    return a[BUS_W-1:8] == REG_PAGE;
  endfunction

  function automatic logic lane_ok(input logic is_byte, input logic a0);
    return !is_byte || a0;
  endfunction
endpackage

// File: rtl/cmap_wdec.sv
module cmap_wdec
  import cmap_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int IDX_W  = 3
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_byte,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BANK_W-1:0] wr_val
);
  logic [15:0] val16;
  logic        unused_bits;

  assign wr_en  = bus_sel && bus_we && in_reg_page(bus_addr)
                  && lane_ok(bus_byte, bus_addr[0]);
  assign wr_idx = bus_addr[IDX_W:1];
  assign val16  = bus_byte ? {8'h00, bus_wdata[7:0]} : bus_wdata;
  assign wr_val = val16[BANK_W-1:0];

  assign unused_bits = ^{val16[15:BANK_W], bus_addr[7:IDX_W+1]};
endmodule

// File: rtl/cmap_regfile.sv
module cmap_regfile #(
  parameter int NUM_WIN = 8,
  parameter int BANK_W  = 6,
  parameter int IDX_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [BANK_W-1:0]              wr_val,
  output logic [NUM_WIN-1:0][BANK_W-1:0] banks
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_reg
    localparam logic [BANK_W-1:0] RST_VAL = BANK_W'(i);
    logic [BANK_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r <= RST_VAL;
      else if (wr_en && wr_idx == IDX_W'(i))
        r <= wr_val;
    end
    assign banks[i] = r;
  end
endmodule

// File: rtl/cmap_xlate.sv
module cmap_xlate
  import cmap_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int BANK_W    = 6,
  parameter int WIN_BITS  = 3,
  parameter int PAGE_BITS = 19
) (
  input  logic                           bus_sel,
  input  logic                           bus_we,
  input  logic [BUS_W-1:0]               bus_addr,
  input  logic [NUM_WIN-1:0][BANK_W-1:0] banks,
  output logic [BANK_W+PAGE_BITS-1:0]    rom_addr,
  output logic                           rom_sel,
  output logic                           save_sel,
  output logic                           save_we,
  output logic [WIN_BITS+PAGE_BITS-2:0]  save_off,
  output logic                           ovl_on
);
  localparam int CART_W = WIN_BITS + PAGE_BITS;
  localparam int PHYS_W = BANK_W + PAGE_BITS;

  function automatic logic [PHYS_W-1:0] map_phys(input logic [BANK_W-1:0] bank,
                                                 input logic [PAGE_BITS-1:0] off);
    return {bank, off};
  endfunction

  logic                cart_hit;
  logic                save_region;
  logic [WIN_BITS-1:0] win;
  logic [BANK_W-1:0]   bank;
  ctl_mode_e           mode;
  logic                unused_bits;

  assign cart_hit    = bus_addr[BUS_W-1:CART_W] == '0;
  assign save_region = bus_addr[CART_W-1];
  assign win         = bus_addr[CART_W-1:PAGE_BITS];
  assign mode        = ctl_mode_e'(banks[0][1:0]);
  assign ovl_on      = banks[0][0];

  assign bank     = (win == '0) ? '0 : banks[win];
  assign rom_addr = map_phys(bank, bus_addr[PAGE_BITS-1:0]);
  assign save_off = bus_addr[CART_W-2:0];

  assign save_sel = bus_sel && cart_hit && save_region && ovl_on;
  assign rom_sel  = bus_sel && cart_hit && !(save_region && ovl_on);
  assign save_we  = save_sel && bus_we && (mode == CTL_SAVE_RW);

  assign unused_bits = ^banks[0][BANK_W-1:2];
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cmap_pkg::*;
#(
  parameter int BANK_W    = 6,
  parameter int WIN_BITS  = 3,
  parameter int PAGE_BITS = 19
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_sel,
  input  logic                                bus_we,
  input  logic                                bus_byte,
  input  logic [23:0]                         bus_addr,
  input  logic [15:0]                         bus_wdata,
  output logic [BANK_W+PAGE_BITS-1:0]         rom_addr,
  output logic                                rom_sel,
  output logic                                save_sel,
  output logic                                save_we,
  output logic [WIN_BITS+PAGE_BITS-2:0]       save_off
);
  localparam int NUM_WIN = 1 << WIN_BITS;
  localparam int IDX_W   = WIN_BITS;

  logic                           wr_en;
  logic [IDX_W-1:0]               wr_idx;
  logic [BANK_W-1:0]              wr_val;
  logic [NUM_WIN-1:0][BANK_W-1:0] banks;
  logic                           ovl_on;

  cmap_wdec #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_wdec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_byte (bus_byte),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val)
  );

  cmap_regfile #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wr_val(wr_val),
    .banks (banks)
  );

  cmap_xlate #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W), .WIN_BITS(WIN_BITS),
               .PAGE_BITS(PAGE_BITS)) u_xlate (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .banks   (banks),
    .rom_addr(rom_addr),
    .rom_sel (rom_sel),
    .save_sel(save_sel),
    .save_we (save_we),
    .save_off(save_off),
    .ovl_on  (ovl_on)
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int NUM_WIN   = 8,
  parameter int BANK_W    = 6,
  parameter int IDX_W     = 3,
  parameter int PAGE_BITS = 19
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_sel,
  input logic                           bus_we,
  input logic [23:0]                    bus_addr,
  input logic                           wr_en,
  input logic [IDX_W-1:0]               wr_idx,
  input logic [BANK_W-1:0]              wr_val,
  input logic [NUM_WIN-1:0][BANK_W-1:0] banks,
  input logic                           ovl_on,
  input logic [BANK_W+PAGE_BITS-1:0]    rom_addr,
  input logic                           rom_sel,
  input logic                           save_sel,
  input logic                           save_we
);
  localparam int CART_W = IDX_W + PAGE_BITS;

  // R4: window 0 lands on page 0
  a_r4_window0_page0: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && bus_addr[CART_W-1:PAGE_BITS] == '0)
      |-> rom_addr[BANK_W+PAGE_BITS-1:PAGE_BITS] == '0);

  // R6: one target per access; overlay follows control bit 0
  a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && save_sel));
  a_r6_overlay_gate: assert property (@(posedge clk) disable iff (!rst_n)
    save_sel |-> ovl_on);

  // R7: qualified save write
  a_r7_we_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    save_we |-> (save_sel && bus_we && banks[0][1:0] == 2'b01));

  // R8: write lands on the next edge
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> banks[$past(wr_idx)] == $past(wr_val));

  // R2: no write event, no register change
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(banks));

  // R9: outside the cartridge window nothing is selected
  a_r9_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[23:CART_W] != '0) |-> (!rom_sel && !save_sel));

  // R10: idle bus is quiet
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (!rom_sel && !save_sel && !save_we && !wr_en));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
  .NUM_WIN(NUM_WIN), .BANK_W(BANK_W), .IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .bus_we  (bus_we),
  .bus_addr(bus_addr),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_val  (wr_val),
  .banks   (banks),
  .ovl_on  (ovl_on),
  .rom_addr(rom_addr),
  .rom_sel (rom_sel),
  .save_sel(save_sel),
  .save_we (save_we)
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [24:0] rom_addr;
  logic        rom_sel, save_sel, save_we;
  logic [20:0] save_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int exp_bank [8];
  int exp_ctrl;

  always #5 clk = ~clk;

  cart_bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rom_addr(rom_addr), .rom_sel(rom_sel), .save_sel(save_sel),
    .save_we(save_we), .save_off(save_off)
  );

  task automatic wr(input logic [23:0] a, input logic [15:0] d, input logic is_byte);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_byte = is_byte; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 0; bus_we = 0;
  endtask

  // Drives one access, compares {rom_sel,save_sel,save_we,address} against the model
  task automatic probe(input logic [23:0] a, input bit we, input bit sel, input string req);
    int cart, win, off, ovl, sreg, bank;
    bit rs, ss, sw;
    logic [27:0] got, exp;
    int val;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_byte = 0; bus_addr = a;
    #1;
    cart = (a < 24'h400000);
    win  = (a >> 19) & 7;
    off  = a & 24'h7FFFF;
    ovl  = exp_ctrl & 1;
    sreg = (a >> 21) & 1;
    ss = sel && cart && sreg && ovl;
    rs = sel && cart && !(sreg && ovl);
    sw = ss && we && ((exp_ctrl & 3) == 1);
    bank = (win == 0) ? 0 : exp_bank[win];
    val = rs ? bank * 32'h80000 + off : (ss ? (a & 24'h1FFFFF) : 0);
    exp = {rs, ss, sw, 25'(val)};
    got = {rom_sel, save_sel, save_we,
           rom_sel ? rom_addr : (save_sel ? {4'b0, save_off} : 25'(0))};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, a, got, exp);
    end
    bus_sel = 0; bus_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_bank[i] = i;
    exp_ctrl = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1: identity after reset, every window
    for (int w = 0; w < 8; w++) probe(24'(w * 32'h80000 + 32'h1234), 0, 1, "R1 reset identity");

    // R2: out-of-page writes ignored, bits 7:4 not decoded
    wr(24'hA13102, 16'h0011, 0);
    wr(24'hA12FF2, 16'h0012, 0);
    probe(24'h080040, 0, 1, "R2 outside page ignored");
    wr(24'hA130F2, 16'h0015, 0);
    exp_bank[1] = 6'h15;
    probe(24'h080040, 0, 1, "R2 index from bits 3:1");

    // R3: byte lanes and word width
    wr(24'hA13002, 16'h0007, 1);
    probe(24'h0A0000, 0, 1, "R3 even byte ignored");
    wr(24'hA13003, 16'hAB27, 1);
    exp_bank[1] = 6'h27;
    probe(24'h0A0000, 0, 1, "R3 odd byte low lane");
    wr(24'hA13004, 16'hFF2A, 0);
    exp_bank[2] = 6'h2A;
    probe(24'h13FFFF, 0, 1, "R3 word write truncated");

    // R5 / R8: sweep all windows and banks; probe right after each write
    for (int w = 1; w < 8; w++) begin
      for (int b = 0; b < 64; b++) begin
        wr(24'(32'hA13000 + 2 * w), 16'(b), 0);
        exp_bank[w] = b;
        probe(24'(w * 32'h80000), 0, 1, "R8 next-cycle visibility");
        probe(24'(w * 32'h80000 + 32'h7FFFF), 0, 1, "R5 window top");
        probe(24'(w * 32'h80000 + ((b * 32'h1357) & 32'h7FFFF)), 0, 1, "R5 window offset");
      end
    end

    // R4: window 0 fixed on page 0 after the sweep
    probe(24'h000000, 0, 1, "R4 window0 base");
    probe(24'h07FFFF, 0, 1, "R4 window0 top");

    // R6: overlay on; then bank rewrite under overlay; then overlay off
    wr(24'hA13000, 16'h0001, 0);
    exp_ctrl = 1;
    probe(24'h200000, 0, 1, "R6 overlay low edge");
    probe(24'h3FFFFF, 0, 1, "R6 overlay high edge");
    probe(24'h2ABCDE, 0, 1, "R6 overlay offset");
    probe(24'h1FFFFF, 0, 1, "R6 below overlay stays ROM");
    wr(24'hA1300A, 16'h0033, 0);
    exp_bank[5] = 6'h33;
    probe(24'h280100, 0, 1, "R6 overlay hides bank write");
    wr(24'hA13001, 16'h0000, 1);
    exp_ctrl = 0;
    probe(24'h280100, 0, 1, "R6 hidden bank appears");

    // R7: write qualification by control value
    wr(24'hA13000, 16'h0001, 0); exp_ctrl = 1;
    probe(24'h200010, 1, 1, "R7 mode 01 write");
    probe(24'h200010, 0, 1, "R7 mode 01 read");
    wr(24'hA13000, 16'h0003, 0); exp_ctrl = 3;
    probe(24'h300010, 1, 1, "R7 mode 11 blocked");
    wr(24'hA13000, 16'h0002, 0); exp_ctrl = 2;
    probe(24'h300010, 1, 1, "R7 mode 10 to ROM");
    wr(24'hA13000, 16'h0001, 0); exp_ctrl = 1;

    // R9 / R10
    probe(24'h400000, 0, 1, "R9 above cartridge");
    probe(24'hA13000, 0, 1, "R9 register page read");
    probe(24'hFF0000, 1, 1, "R9 high write");
    probe(24'h100000, 0, 0, "R10 idle ROM address");
    probe(24'h200000, 1, 0, "R10 idle save write");
    wr(24'hA13000, 16'h0000, 0); exp_ctrl = 0;
    @(negedge clk);
    bus_sel = 0; bus_we = 1; bus_addr = 24'hA1300C; bus_wdata = 16'h003C;
    @(posedge clk);
    #1 bus_we = 0;
    probe(24'h300000, 0, 1, "R10 unselected register write");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule